// File: doc/BRIEF.md
# Fused Multiply-Add Sum and Normalize Stage

This stage finishes a double-precision fused multiply-add once the special operands (NaN, infinity, zero product) have been handled upstream. It takes the full-width product of two significands, with the product's exponent and sign, and a normalized addend significand with its own exponent and sign. It lines the two operands up, adds or subtracts their magnitudes and normalizes the result again. It then hands a 56-bit significand to a separate rounding stage: 53 significant bits followed by guard, round and sticky positions.

Every right shift folds the bits it drops into a sticky bit, and the product is never truncated before the addition. The whole operation is therefore rounded only once, later, by the rounding stage. The datapath is combinational and ends in one output register. A result is presented one cycle after its operands arrive, marked by a valid flag.

Exponents are unbiased two's-complement values. The stage does not check them for range.

Top module: `fma_sum_norm`

## Requirements
- R1: `out_valid` is high in exactly the cycle after `in_valid` was high. While `in_valid` is low the result outputs keep their last values.
- R2: While `rst` is high, `out_valid`, `res_mant`, `res_exp` and `res_sign` are all zero.
- R3: The incoming product has its leading one at bit 127 or bit 126. If bit 127 is set, the product is shifted right by one with sticky and its exponent is increased by one.
- R4: When `add_is_zero` is high, the result is the normalized product shifted right by 71 with sticky, keeping the low 56 bits, with the product's sign and exponent. `add_mant`, `add_exp`, `add_sign` and `round_down` have no effect on this result.
- R5: The addend significand has its leading one at bit 52. It is placed in the wide datapath at bits 126..74, with zeros below.
- R6: The operand with the smaller exponent is shifted right by the exponent difference, with sticky, and the larger exponent becomes the common one. If the exponents are equal the product is the one shifted, by zero. A shift of 128 or more leaves only the sticky bit, at bit 0.
- R7: When the signs agree, the magnitudes are added and the result takes that sign. A carry into bit 127 causes a sticky right shift by one and increases the exponent by one.
- R8: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R9: On an exact cancellation the result is `res_mant` = 0 and `res_exp` = 0. `res_sign` equals `round_down` (1 gives -0, 0 gives +0).
- R10: A nonzero difference is shifted left until its leading one sits at bit 126, and the exponent is decreased by the shift amount. Shifts of up to 126 places are supported.
- R11: The normalized sum is shifted right by 71 with sticky. Every nonzero `res_mant` has bit 55 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| prod_mant | input | 128 | Significand product, leading one at bit 127 or 126 |
| prod_exp | input | 14 | Signed exponent of the product |
| prod_sign | input | 1 | Sign of the product |
| add_mant | input | 53 | Addend significand, leading one at bit 52 |
| add_exp | input | 14 | Signed exponent of the addend |
| add_sign | input | 1 | Sign of the addend |
| add_is_zero | input | 1 | Addend is zero; pass the product through |
| round_down | input | 1 | Rounding is toward negative infinity (sign of an exact zero) |
| out_valid | output | 1 | Result is valid |
| res_mant | output | 56 | Significand with 3 low guard bits, leading one at bit 55 |
| res_exp | output | 14 | Signed result exponent |
| res_sign | output | 1 | Result sign |

## Verification
Alignment and renormalization can both act on a single operation. A far-shifted product can leave a one only at bit 0 of the difference, which then needs the longest left shift of 126 places. Directed cases provoke this by pairing an addend at bit 126 with a product at bits 126 and 0, opposite in sign, and also at near-equal exponents where sticky bits and carries borrow through the subtraction. Random cases with exponents within two of each other add more such collisions. The bench judges every case against an independent bit-serial model of the requirements.

// File: rtl/fma_pkg.sv
package fma_pkg;

    localparam int PROD_W   = 128;
    localparam int ADD_W    = 53;
    localparam int OUT_W    = 56;
    localparam int EXP_W    = 14;
    localparam int LEAD     = PROD_W - 2;
    localparam int ADD_SH   = LEAD - (ADD_W - 1);
    localparam int FINAL_SH = LEAD - (OUT_W - 1);
    localparam int SH_W     = $clog2(PROD_W) + 1;
    localparam int POS_W    = $clog2(PROD_W);

    typedef logic signed [EXP_W-1:0] sexp_t;
    typedef logic [PROD_W-1:0]       wide_t;

    typedef struct packed {
        logic  sign;
        sexp_t exp;
        wide_t mag;
    } wide_op_t;

    typedef struct packed {
        logic             sign;
        sexp_t            exp;
        logic [OUT_W-1:0] mant;
    } fma_res_t;

    // Right shift; everything shifted out is ORed into bit 0.
    function automatic wide_t shr_sticky(wide_t v, logic [SH_W-1:0] n);
        wide_t mask;
        wide_t r;
        if (n >= SH_W'(PROD_W)) begin
            return {{(PROD_W-1){1'b0}}, |v};
        end
        mask = ~({PROD_W{1'b1}} << n);
        r    = v >> n;
        r[0] = r[0] | (|(v & mask));
        return r;
    endfunction

    // Non-negative exponent difference saturated to the datapath width.
    function automatic logic [SH_W-1:0] clamp_shift(sexp_t d);
        if (d >= sexp_t'(PROD_W)) begin
            return SH_W'(PROD_W);
        end
        return d[SH_W-1:0];
    endfunction

    // Drop the wide significand down to the rounding-stage width.
    function automatic logic [OUT_W-1:0] reduce_out(wide_t v);
        wide_t r;
        r = shr_sticky(v, SH_W'(FINAL_SH));
        return r[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/fma_lzc.sv
module fma_lzc #(
    parameter int W = 128,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] lead_pos
);
    // Priority encoder: the highest set bit wins.
    always_comb begin
        lead_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                lead_pos = PW'(i);
            end
        end
    end
endmodule

// File: rtl/fma_align.sv
module fma_align
    import fma_pkg::*;
(
    input  wide_op_t prod_in,
    input  wide_op_t add_in,
    output wide_t    prod_al,
    output wide_t    add_al,
    output sexp_t    exp_c
);
    sexp_t diff;

    always_comb begin
        if (add_in.exp > prod_in.exp) begin
            diff    = add_in.exp - prod_in.exp;
            prod_al = shr_sticky(prod_in.mag, clamp_shift(diff));
            add_al  = add_in.mag;
            exp_c   = add_in.exp;
        end else begin
            diff    = prod_in.exp - add_in.exp;
            add_al  = shr_sticky(add_in.mag, clamp_shift(diff));
            prod_al = prod_in.mag;
            exp_c   = prod_in.exp;
        end
    end
endmodule

// File: rtl/fma_addsub.sv
module fma_addsub
    import fma_pkg::*;
(
    input  wide_t    p_mag,
    input  logic     p_sign,
    input  wide_t    a_mag,
    input  logic     a_sign,
    input  sexp_t    exp_c,
    input  logic     round_down,
    output wide_op_t sum_out
);
    wide_t            diff_mag;
    logic             diff_sign;
    logic [POS_W-1:0] lead_pos;
    logic [POS_W-1:0] lsh;
    wide_t            total;

    always_comb begin
        if (a_mag >= p_mag) begin
            diff_mag  = a_mag - p_mag;
            diff_sign = a_sign;
        end else begin
            diff_mag  = p_mag - a_mag;
            diff_sign = p_sign;
        end
    end

    fma_lzc #(.W(PROD_W)) u_lzc (
        .vec      (diff_mag),
        .lead_pos (lead_pos)
    );

    assign lsh   = POS_W'(LEAD) - lead_pos;
    assign total = a_mag + p_mag;

    always_comb begin
        if (a_sign == p_sign) begin
            sum_out.sign = a_sign;
            if (total[PROD_W-1]) begin
                sum_out.mag = shr_sticky(total, SH_W'(1));
                sum_out.exp = exp_c + sexp_t'(1);
            end else begin
                sum_out.mag = total;
                sum_out.exp = exp_c;
            end
        end else if (diff_mag == '0) begin
            sum_out.sign = round_down;
            sum_out.exp  = '0;
            sum_out.mag  = '0;
        end else begin
            sum_out.sign = diff_sign;
            sum_out.mag  = diff_mag << lsh;
            sum_out.exp  = exp_c - sexp_t'(lsh);
        end
    end
endmodule

// File: rtl/fma_sum_norm.sv
module fma_sum_norm
    import fma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [127:0]            prod_mant,
    input  logic signed [13:0]      prod_exp,
    input  logic                    prod_sign,
    input  logic [52:0]             add_mant,
    input  logic signed [13:0]      add_exp,
    input  logic                    add_sign,
    input  logic                    add_is_zero,
    input  logic                    round_down,
    output logic                    out_valid,
    output logic [55:0]             res_mant,
    output logic signed [13:0]      res_exp,
    output logic                    res_sign
);
    wide_op_t pn;
    wide_op_t an;
    wide_t    p_al;
    wide_t    a_al;
    sexp_t    exp_c;
    wide_op_t summed;
    wide_op_t chosen;
    fma_res_t nxt;
    fma_res_t cur;

    // Product: pull a leading one at the top bit down to the lead position.
    always_comb begin
        pn.sign = prod_sign;
        if (prod_mant[PROD_W-1]) begin
            pn.mag = shr_sticky(prod_mant, SH_W'(1));
            pn.exp = prod_exp + sexp_t'(1);
        end else begin
            pn.mag = prod_mant;
            pn.exp = prod_exp;
        end
    end

    // Addend: leading one moved to the lead position.
    always_comb begin
        an.sign = add_sign;
        an.exp  = add_exp;
        an.mag  = wide_t'(add_mant) << ADD_SH;
    end

    fma_align u_align (
        .prod_in (pn),
        .add_in  (an),
        .prod_al (p_al),
        .add_al  (a_al),
        .exp_c   (exp_c)
    );

    fma_addsub u_addsub (
        .p_mag      (p_al),
        .p_sign     (pn.sign),
        .a_mag      (a_al),
        .a_sign     (an.sign),
        .exp_c      (exp_c),
        .round_down (round_down),
        .sum_out    (summed)
    );

    assign chosen   = add_is_zero ? pn : summed;
    assign nxt.sign = chosen.sign;
    assign nxt.exp  = chosen.exp;
    assign nxt.mant = reduce_out(chosen.mag);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cur <= nxt;
            end
        end
    end

    assign res_mant = cur.mant;
    assign res_exp  = cur.exp;
    assign res_sign = cur.sign;
endmodule

// File: rtl/fma_sum_norm_chk.sv
module fma_sum_norm_chk (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               prod_sign,
    input logic               add_is_zero,
    input logic               round_down,
    input logic               out_valid,
    input logic [55:0]        res_mant,
    input logic signed [13:0] res_exp,
    input logic               res_sign
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_result_held_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_mant) && $stable(res_exp) && $stable(res_sign)));

    assert_passthrough_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && add_is_zero) |=> (res_sign == $past(prod_sign)));

    assert_cancel_sign_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_mant == 56'd0) |-> (res_sign == $past(round_down)));

    assert_cancel_exp_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_mant == 56'd0) |-> (res_exp == 14'sd0));

    assert_lead_bit_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_mant != 56'd0) |-> res_mant[55]);
endmodule

bind fma_sum_norm fma_sum_norm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .prod_sign   (prod_sign),
    .add_is_zero (add_is_zero),
    .round_down  (round_down),
    .out_valid   (out_valid),
    .res_mant    (res_mant),
    .res_exp     (res_exp),
    .res_sign    (res_sign)
);

// File: tb/fma_sum_norm_test.sv
`timescale 1ns/1ps
module fma_sum_norm_test;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [127:0]       prod_mant = '0;
    logic signed [13:0] prod_exp = '0;
    logic               prod_sign = 1'b0;
    logic [52:0]        add_mant = '0;
    logic signed [13:0] add_exp = '0;
    logic               add_sign = 1'b0;
    logic               add_is_zero = 1'b0;
    logic               round_down = 1'b0;
    logic               out_valid;
    logic [55:0]        res_mant;
    logic signed [13:0] res_exp;
    logic               res_sign;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    fma_sum_norm uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .prod_mant(prod_mant), .prod_exp(prod_exp), .prod_sign(prod_sign),
        .add_mant(add_mant), .add_exp(add_exp), .add_sign(add_sign),
        .add_is_zero(add_is_zero), .round_down(round_down),
        .out_valid(out_valid), .res_mant(res_mant), .res_exp(res_exp),
        .res_sign(res_sign)
    );

    function automatic logic [127:0] ref_shr(logic [127:0] v, int n);
        logic st = 1'b0;
        if (n >= 128) return {127'b0, |v};
        for (int i = 0; i < n; i++) begin
            st = st | v[0];
            v  = v >> 1;
        end
        v[0] = v[0] | st;
        return v;
    endfunction

    task automatic ref_model(
        input logic [127:0] pm, input int pe_in, input logic ps,
        input logic [52:0] am, input int ae, input logic as_,
        input logic az, input logic rd,
        output logic [55:0] om, output int oe, output logic os);
        logic [127:0] p;
        logic [127:0] a;
        logic [127:0] r;
        int pe;
        int e;
        p  = pm;
        pe = pe_in;
        if (p[127]) begin p = ref_shr(p, 1); pe++; end
        if (az) begin
            r = ref_shr(p, 71); om = r[55:0]; oe = pe; os = ps;
            return;
        end
        a = {1'b0, am, 74'b0};
        if (ae > pe) begin p = ref_shr(p, ae - pe); e = ae; end
        else begin a = ref_shr(a, pe - ae); e = pe; end
        if (ps == as_) begin
            r = p + a; os = ps;
            if (r[127]) begin r = ref_shr(r, 1); e++; end
        end else begin
            if (a >= p) begin r = a - p; os = as_; end
            else begin r = p - a; os = ps; end
            if (r == 128'd0) begin om = '0; oe = 0; os = rd; return; end
            while (!r[126]) begin r = r << 1; e--; end
        end
        r  = ref_shr(r, 71);
        om = r[55:0];
        oe = e;
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    task automatic run_case(input string tag,
        input logic [127:0] pm, input int pe, input logic ps,
        input logic [52:0] am, input int ae, input logic as_,
        input logic az, input logic rd);
        logic [55:0] em;
        int ee;
        logic es;
        ref_model(pm, pe, ps, am, ae, as_, az, rd, em, ee, es);
        @(negedge clk);
        prod_mant = pm; prod_exp = 14'(pe); prod_sign = ps;
        add_mant = am; add_exp = 14'(ae); add_sign = as_;
        add_is_zero = az; round_down = rd; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_tests++;
        if (!out_valid || res_mant !== em || res_exp !== 14'(ee) || res_sign !== es) begin
            n_fail++;
            $display("FAIL %s result: actual v=%b m=%h e=%0d s=%b expected v=1 m=%h e=%0d s=%b",
                     tag, out_valid, res_mant, res_exp, res_sign, em, 14'(ee), es);
        end
        if (res_mant != 56'd0) begin
            check("R11", res_mant[55], "lead bit 55", 64'(res_mant[55]), 64'd1);
        end
    endtask

    function automatic logic [127:0] rnd_prod();
        logic [127:0] p;
        p = {$urandom(), $urandom(), $urandom(), $urandom()};
        if (!p[127]) p[126] = 1'b1;
        return p;
    endfunction

    function automatic logic [52:0] rnd_add();
        logic [52:0] a;
        a = {$urandom(), $urandom()};
        a[52] = 1'b1;
        return a;
    endfunction

    localparam logic [127:0] P_LEAD = {2'b01, 126'b0};
    localparam logic [52:0]  A_LEAD = {1'b1, 52'b0};

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [55:0] hm;
        logic [13:0] he;
        logic        hs;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: outputs cleared during reset
        check("R2", out_valid == 1'b0, "valid in reset", 64'(out_valid), 64'd0);
        check("R2", res_mant == 56'd0 && res_exp == 14'sd0 && res_sign == 1'b0,
              "result in reset", 64'(res_mant), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R5: addend far above product, product collapses to sticky
        run_case("R5", P_LEAD, 0, 1'b0, A_LEAD | 53'h5, 300, 1'b0, 1'b0, 1'b0);
        // R3 / R4: product with bit 127 set, addend ignored
        run_case("R3", {1'b1, 126'h0, 1'b1}, 40, 1'b1, rnd_add(), 7, 1'b0, 1'b1, 1'b1);
        run_case("R4", P_LEAD | 128'h3, -20, 1'b0, rnd_add(), 900, 1'b1, 1'b1, 1'b1);
        // R6: shifts beyond width in both directions and equal exponents
        run_case("R6", rnd_prod(), 500, 1'b0, rnd_add(), -100, 1'b0, 1'b0, 1'b0);
        run_case("R6", rnd_prod(), 10, 1'b1, rnd_add(), 140, 1'b1, 1'b0, 1'b0);
        run_case("R6", rnd_prod(), 33, 1'b0, rnd_add(), 33, 1'b0, 1'b0, 1'b0);
        // R7: carry into the top bit
        run_case("R7", {1'b0, {127{1'b1}}}, 5, 1'b0, {53{1'b1}}, 5, 1'b0, 1'b0, 1'b0);
        // R8: larger product decides the sign
        run_case("R8", {2'b01, 126'h1234}, 12, 1'b1, A_LEAD, 11, 1'b0, 1'b0, 1'b0);
        run_case("R8", P_LEAD, 3, 1'b0, {53{1'b1}}, 3, 1'b1, 1'b0, 1'b0);
        // R9: exact cancellation, both rounding directions
        run_case("R9", P_LEAD, 17, 1'b0, A_LEAD, 17, 1'b1, 1'b0, 1'b0);
        run_case("R9", P_LEAD, -4, 1'b1, A_LEAD, -4, 1'b0, 1'b0, 1'b1);
        // R10: deepest left renormalization and a sticky-borrow case
        run_case("R10", P_LEAD | 128'h1, 0, 1'b1, A_LEAD, 0, 1'b0, 1'b0, 1'b0);
        run_case("R10", P_LEAD | 128'h1, 2, 1'b0, A_LEAD, 3, 1'b1, 1'b0, 1'b0);

        // R1: result held while idle, valid low
        hm = res_mant; he = res_exp; hs = res_sign;
        @(negedge clk);
        prod_mant = rnd_prod(); add_mant = rnd_add(); prod_sign = ~prod_sign;
        add_exp = 14'sd77;
        repeat (2) @(negedge clk);
        check("R1", out_valid == 1'b0, "valid idle", 64'(out_valid), 64'd0);
        check("R1", res_mant == hm && res_exp == he && res_sign == hs,
              "held result", 64'(res_mant), 64'(hm));

        // Random mix, exponents often close for cancellation
        for (int k = 0; k < 600; k++) begin
            logic [127:0] pm;
            logic [52:0]  am;
            int pe;
            int ae;
            int cls;
            pm  = rnd_prod();
            am  = rnd_add();
            pe  = int'($urandom_range(1200)) - 600;
            cls = int'($urandom_range(3));
            if (cls == 0) ae = pe + int'($urandom_range(4)) - 2;
            else ae = int'($urandom_range(1200)) - 600;
            if (cls == 3 && k % 2 == 0) begin
                pm = {1'b0, 1'b1, am[51:0], 74'b0} ^ 128'(1 << ($urandom_range(20)));
                ae = pe;
            end
            run_case((cls == 0) ? "R10" : "R6", pm, pe, $urandom_range(1) == 1,
                     am, ae, $urandom_range(1) == 1, $urandom_range(15) == 0,
                     $urandom_range(1) == 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule